// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves data between two 18-bit ports, A and B, through two fully independent storage paths: one from A to B, one from B to A. Each path keeps one storage register that can pass its input straight through, hold its content, or capture its input on a rising edge of a per-direction capture clock. That capture edge is qualified by an active-low enable. A level-sensitive latch enable picks between the pass-through behaviour and the edge-captured behaviour.

The design is fully synchronous to one system clock with a synchronous active-high reset. The per-direction capture clocks are sampled as ordinary inputs and edge-detected. "Transparent" therefore means that the output register follows the input with one system-clock cycle of latency. Tri-state outputs are modelled as a data bus plus a registered drive-enable flag.

Each input port has a valid flag. While that flag is low, the path uses the last value that was seen while the flag was high, so an undriven bus never presents an unknown value.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both stored values become zero and both drive-enable outputs become 0 after that edge.
- R2: When a path's latch enable is 1 at a clock edge, that path's output data after the edge equals the path's effective input at that edge.
- R3: When a path's latch enable is 0 and no qualified capture edge occurs, that path's output data stays unchanged across the clock edge.
- R4: A capture edge is a clock edge at which the path's capture clock is sampled 1 after being sampled 0 at the previous edge. With latch enable 0 and the active-low capture enable at 0, a capture edge loads the effective input.
- R5: A capture edge that arrives while the active-low capture enable is 1 leaves the stored value unchanged.
- R6: Latch enable has priority. With latch enable 1, the path loads at every edge, whatever the capture clock and the capture enable are doing.
- R7: When latch enable falls, the path keeps the value it loaded at the last edge at which latch enable was still 1.
- R8: A path's drive-enable output equals the inverse of its active-low output enable sampled at the previous edge. Storage keeps updating while the drive-enable is 0.
- R9: The two directions are independent. Controls and data of one path never change the other path's outputs.
- R10: The effective input is the port input while its valid flag is 1. While the flag is 0, it is the last port value seen with the flag at 1, or zero if no such value has been seen since reset.
- R11: A capture clock that is already 1 when reset is released produces no capture edge until it has been sampled 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Port A incoming data |
| a_in_vld | input | 1 | Port A is being driven |
| b_in | input | 18 | Port B incoming data |
| b_in_vld | input | 1 | Port B is being driven |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_clk | input | 1 | A-to-B capture clock (sampled) |
| ab_clk_en_n | input | 1 | A-to-B capture enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_clk | input | 1 | B-to-A capture clock (sampled) |
| ba_clk_en_n | input | 1 | B-to-A capture enable, active low |
| b_out | output | 18 | Data driven onto port B |
| b_out_en | output | 1 | Port B drive enable |
| a_out | output | 18 | Data driven onto port A |
| a_out_en | output | 1 | Port A drive enable |

## Verification
Two things can happen in the same cycle: latch enable can be high while a capture edge arrives, and a capture edge can arrive while the capture enable is off. The bench provokes both together by raising the capture clock while latch enable is 1 and the capture enable is deasserted. It judges the result against a behavioural reference model that loads whenever latch enable is high. It also drops latch enable in the cycle after a data change, and it releases reset with the capture clock already high. In both cases the model says exactly which sampled value must be frozen.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef struct packed {
    logic oe_n;
    logic le;
    logic cap;
    logic cen_n;
  } bxr_ctl_t;
  localparam int unsigned NDIR = 2;
endpackage

// File: rtl/bxr_keep.sv
module bxr_keep #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         vld,
  output logic [W-1:0] eff
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else if (vld) hold_q <= din;
  end

  assign eff = vld ? din : hold_q;

  AST_KEEP_LAST: assert property (@(posedge clk) disable iff (rst)
    (vld ##1 !vld) |-> (eff == $past(din))); // R10
endmodule

// File: rtl/bxr_edge.sv
module bxr_edge (
  input  logic clk,
  input  logic rst,
  input  logic cap,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else prev_q <= cap;
  end

  assign rise = cap & ~prev_q;

  AST_NO_LEVEL_EDGE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R4
endmodule

// File: rtl/bxr_path.sv
module bxr_path
  import bxr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  bxr_ctl_t     ctl,
  output logic [W-1:0] q,
  output logic         en
);
  logic         rise;
  logic         load;
  logic [W-1:0] st_q;
  logic         en_q;

  bxr_edge i_edge (
    .clk  (clk),
    .rst  (rst),
    .cap  (ctl.cap),
    .rise (rise)
  );

  assign load = ctl.le | (rise & ~ctl.cen_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      en_q <= 1'b0;
    end else begin
      if (load) st_q <= din;
      en_q <= ~ctl.oe_n;
    end
  end

  assign q  = st_q;
  assign en = en_q;

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    ctl.le |=> (q == $past(din))); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctl.le && !(rise && !ctl.cen_n)) |=> $stable(q)); // R3
  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!ctl.le && rise && !ctl.cen_n) |=> (q == $past(din))); // R4
  AST_GATED_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!ctl.le && rise && ctl.cen_n) |=> $stable(q)); // R5
  AST_DRIVE_EN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (en == !$past(ctl.oe_n))); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (q == '0 && !en)); // R1
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import bxr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         a_in_vld,
  input  logic [W-1:0] b_in,
  input  logic         b_in_vld,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_clk_en_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_clk_en_n,
  output logic [W-1:0] b_out,
  output logic         b_out_en,
  output logic [W-1:0] a_out,
  output logic         a_out_en
);
  logic [W-1:0] src  [NDIR];
  logic         vld  [NDIR];
  logic [W-1:0] eff  [NDIR];
  bxr_ctl_t     ctl  [NDIR];
  logic [W-1:0] q    [NDIR];
  logic         en   [NDIR];

  // index 0: A to B, index 1: B to A
  assign src[0] = a_in;
  assign vld[0] = a_in_vld;
  assign src[1] = b_in;
  assign vld[1] = b_in_vld;
  assign ctl[0] = '{oe_n: ab_oe_n, le: ab_le, cap: ab_clk, cen_n: ab_clk_en_n};
  assign ctl[1] = '{oe_n: ba_oe_n, le: ba_le, cap: ba_clk, cen_n: ba_clk_en_n};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    bxr_keep #(.W(W)) i_keep (
      .clk (clk),
      .rst (rst),
      .din (src[d]),
      .vld (vld[d]),
      .eff (eff[d])
    );
    bxr_path #(.W(W)) i_path (
      .clk (clk),
      .rst (rst),
      .din (eff[d]),
      .ctl (ctl[d]),
      .q   (q[d]),
      .en  (en[d])
    );
  end

  assign b_out    = q[0];
  assign b_out_en = en[0];
  assign a_out    = q[1];
  assign a_out_en = en[1];

  AST_BA_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && $stable(ba_clk)) |=> $stable(a_out)); // R9
endmodule

// File: tb/test_bidir_reg_xcvr.sv
module test_bidir_reg_xcvr;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in;
  logic         a_in_vld, b_in_vld;
  logic         ab_oe_n, ab_le, ab_clk, ab_clk_en_n;
  logic         ba_oe_n, ba_le, ba_clk, ba_clk_en_n;
  logic [W-1:0] b_out, a_out;
  logic         b_out_en, a_out_en;

  int total = 0;
  int bad   = 0;
  string tag = "R1";

  // reference model state, index 0 = A to B, 1 = B to A
  logic [W-1:0] m_st   [2];
  logic         m_en   [2];
  logic [W-1:0] m_hold [2];
  logic         m_prev [2];

  always #5 clk = ~clk;

  bidir_reg_xcvr #(.W(W)) i_bidir_reg_xcvr (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_in_vld(a_in_vld), .b_in(b_in), .b_in_vld(b_in_vld),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_clk_en_n(ab_clk_en_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_clk_en_n(ba_clk_en_n),
    .b_out(b_out), .b_out_en(b_out_en), .a_out(a_out), .a_out_en(a_out_en)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_dir(input int d, input logic [W-1:0] s, input logic v,
                           input logic oe_n, input logic le, input logic cap, input logic cen_n);
    logic [W-1:0] e;
    logic r;
    if (rst) begin
      m_st[d] = '0; m_en[d] = 1'b0; m_hold[d] = '0; m_prev[d] = 1'b1;
    end else begin
      e = v ? s : m_hold[d];
      r = cap && !m_prev[d];
      if (le || (r && !cen_n)) m_st[d] = e;
      m_en[d] = !oe_n;
      m_prev[d] = cap;
      if (v) m_hold[d] = s;
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_dir(0, a_in, a_in_vld, ab_oe_n, ab_le, ab_clk, ab_clk_en_n);
      model_dir(1, b_in, b_in_vld, ba_oe_n, ba_le, ba_clk, ba_clk_en_n);
      @(negedge clk);
      chk(tag, b_out, m_st[0], "b_out");
      chk(tag, {{(W-1){1'b0}}, b_out_en}, {{(W-1){1'b0}}, m_en[0]}, "b_out_en");
      chk(tag, a_out, m_st[1], "a_out");
      chk(tag, {{(W-1){1'b0}}, a_out_en}, {{(W-1){1'b0}}, m_en[1]}, "a_out_en");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    a_in = 18'h3ffff; b_in = 18'h2aaaa; a_in_vld = 1'b1; b_in_vld = 1'b1;
    ab_oe_n = 1'b0; ab_le = 1'b1; ab_clk = 1'b0; ab_clk_en_n = 1'b0;
    ba_oe_n = 1'b0; ba_le = 1'b1; ba_clk = 1'b0; ba_clk_en_n = 1'b0;
    @(negedge clk);
    tag = "R1"; step(2);
    chk("R1", b_out, '0, "b_out after reset");
    chk("R1", {17'b0, a_out_en}, '0, "a_out_en after reset");
    rst = 1'b0;

    // R2 transparent pass-through, several patterns
    tag = "R2";
    a_in = 18'h12345; step(1);
    chk("R2", b_out, 18'h12345, "b_out transparent");
    a_in = 18'h0f0f0; step(1);
    a_in = 18'h3ffff; step(1);
    b_in = 18'h00001; step(2);
    chk("R2", a_out, 18'h00001, "a_out transparent");

    // R3 hold with steady capture clock
    tag = "R3";
    ab_le = 1'b0; a_in = 18'h11111; step(1);
    chk("R3", b_out, 18'h3ffff, "b_out held");
    a_in = 18'h22222; step(2);
    ab_clk = 1'b1; ab_clk_en_n = 1'b1; step(1);
    ab_clk_en_n = 1'b0; a_in = 18'h33333; step(2);
    chk("R3", b_out, 18'h3ffff, "b_out held with clk high");

    // R4 qualified capture
    tag = "R4";
    ab_clk = 1'b0; step(1);
    a_in = 18'h0abcd; ab_clk = 1'b1; step(1);
    chk("R4", b_out, 18'h0abcd, "b_out captured");
    a_in = 18'h00042; step(1);
    chk("R4", b_out, 18'h0abcd, "no capture on level");

    // R5 gated edge
    tag = "R5";
    ab_clk = 1'b0; step(1);
    ab_clk_en_n = 1'b1; ab_clk = 1'b1; a_in = 18'h15555; step(1);
    chk("R5", b_out, 18'h0abcd, "gated edge ignored");

    // R6 latch enable wins over gated edge in the same cycle
    tag = "R6";
    ab_clk = 1'b0; step(1);
    ab_le = 1'b1; ab_clk = 1'b1; a_in = 18'h2c0de; step(1);
    chk("R6", b_out, 18'h2c0de, "le priority");

    // R7 latch enable falling freezes last passed value
    tag = "R7";
    a_in = 18'h01010; step(1);
    ab_le = 1'b0; a_in = 18'h3eeee; step(2);
    chk("R7", b_out, 18'h01010, "frozen value");

    // R8 drive enable and storage updates while disabled
    tag = "R8";
    ab_oe_n = 1'b1; step(1);
    chk("R8", {17'b0, b_out_en}, '0, "b_out_en off");
    ab_le = 1'b1; a_in = 18'h00777; step(1);
    ab_le = 1'b0; ab_oe_n = 1'b0; step(1);
    chk("R8", {17'b0, b_out_en}, 18'd1, "b_out_en on");
    chk("R8", b_out, 18'h00777, "stored while disabled");

    // R9 independence: B-to-A activity while A-to-B holds
    tag = "R9";
    ba_le = 1'b0; b_in = 18'h09999; step(1);
    ba_clk = 1'b1; step(1);
    chk("R9", a_out, 18'h09999, "ba captured");
    chk("R9", b_out, 18'h00777, "ab untouched");
    ba_oe_n = 1'b1; ba_le = 1'b1; b_in = 18'h1beef; step(2);
    chk("R9", b_out, 18'h00777, "ab untouched 2");

    // R10 input hold while undriven
    tag = "R10";
    ab_le = 1'b1; a_in = 18'h05a5a; step(1);
    a_in_vld = 1'b0; a_in = 18'h3ffff; step(2);
    chk("R10", b_out, 18'h05a5a, "last driven value");
    a_in_vld = 1'b1; a_in = 18'h00003; step(1);
    chk("R10", b_out, 18'h00003, "driven again");

    // R11 no false edge at reset release with clock high
    tag = "R11";
    rst = 1'b1; ab_le = 1'b0; ab_clk = 1'b1; ab_clk_en_n = 1'b0; a_in = 18'h24680; step(1);
    rst = 1'b0; step(2);
    chk("R11", b_out, '0, "no capture at release");
    ab_clk = 1'b0; step(1);
    ab_clk = 1'b1; step(1);
    chk("R11", b_out, 18'h24680, "capture after low");

    // mixed pattern, both directions, compared every cycle
    tag = "R9";
    for (int k = 0; k < 400; k++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      a_in_vld = $urandom_range(0, 3) != 0; b_in_vld = $urandom_range(0, 3) != 0;
      ab_oe_n = $urandom_range(0, 1) == 1; ab_le = $urandom_range(0, 3) == 0;
      ab_clk = $urandom_range(0, 1) == 1; ab_clk_en_n = $urandom_range(0, 2) == 0;
      ba_oe_n = $urandom_range(0, 1) == 1; ba_le = $urandom_range(0, 3) == 0;
      ba_clk = $urandom_range(0, 1) == 1; ba_clk_en_n = $urandom_range(0, 2) == 0;
      step(1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule